// File: doc/BRIEF.md
# Interrupt Source Routing Crossbar

This block sits in front of an interrupt controller. It maps a wide set of peripheral request lines onto a narrower set of controller inputs. Each controller input that can be routed owns a select register. The register holds the number of the source request that drives that input. Requests are active-high levels, and they pass through the block as pure combinational logic. Nothing is latched, and no edge is detected.

Some controller inputs never pass through a multiplexer. Reserved inputs carry their own hard-wired request and have no select register. Skipped inputs keep a readable, writable select register, but their hard-wired request still wins, so the value in that register never steers anything. At reset, every select register is parked on a safe source number. A select value that names no real source holds its output low.

Software reaches the select registers through a small 32-bit bus. The bus uses a byte address, byte write strobes and a one-cycle read latency.

Top module: `irq_route_xbar`

## Requirements
- R1: A routed output equals the level of source line `src_irq[sel]` in the same cycle, where `sel` is that output's select value and `sel` < N_SRC.
- R2: A routed output whose select value is N_SRC or greater is held at 0, whatever the source lines do.
- R3: An output whose bit is set in RSV_MASK always equals `hw_irq` at the same bit position, and it takes no register slot.
- R4: An output whose bit is set in SKIP_MASK always equals `hw_irq` at the same bit position. It still owns a slot that can be written and read back, and writes to that slot leave the output unchanged.
- R5: Register slots are given to the outputs not in RSV_MASK in ascending output order. Slot s occupies bytes s*ELEM_BYTES up to s*ELEM_BYTES+ELEM_BYTES-1, least significant byte first.
- R6: After reset, every slot holds SAFE_SEL, zero-extended to ELEM_BYTES bytes, and `rdata` is 0.
- R7: When `rd_en` is high, on the next cycle `rdata` byte lane l shows register byte (addr with bits 1:0 cleared)+l. A lane that falls outside the register bytes reads 0.
- R8: When `wr_en` is high, only the bytes whose `wstrb` lane is set are updated. Bytes outside the register space are not stored. A read in the same cycle returns the value held before the write.
- R9: On the cycle after a cycle with `rd_en` low, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write enable |
| rd_en | input | 1 | Register read enable |
| addr | input | AW | Byte address |
| wdata | input | 32 | Write data, byte lane l carries the byte for address base+l |
| wstrb | input | 4 | Byte write strobes |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| src_irq | input | N_SRC | Peripheral request levels |
| hw_irq | input | N_OUT | Hard-wired requests for reserved and skipped outputs |
| irq_out | output | N_OUT | Requests presented to the interrupt controller |

## Verification
A corrupt select byte shows up on `irq_out` in the same cycle as soon as the source it wrongly names differs from the intended one. It also shows up on `rdata` one cycle after a read of that word. Reserved and skipped outputs are compared against `hw_irq` on every cycle, so a bypass decode error shows within a cycle of any toggle of that line. The source and hard-wired lines are driven with fresh random levels on every cycle, so a mis-routed slot or a misplaced byte lane diverges from the model within a few cycles.

// File: rtl/irq_route_xbar.sv
module irq_route_xbar #(
  parameter int N_OUT      = 160,
  parameter int N_SRC      = 400,
  parameter int ELEM_BYTES = 2,
  parameter int AW         = 12,
  parameter int SAFE_SEL   = 0,
  parameter logic [N_OUT-1:0] RSV_MASK  = N_OUT'((160'd1 << 131) | (160'd1 << 132) | 160'h6F),
  parameter logic [N_OUT-1:0] SKIP_MASK = N_OUT'((160'd1 << 10) | (160'd1 << 133) | (160'd1 << 139) | (160'd1 << 140))
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [31:0]      wdata,
  input  logic [3:0]       wstrb,
  output logic [31:0]      rdata,
  input  logic [N_SRC-1:0] src_irq,
  input  logic [N_OUT-1:0] hw_irq,
  output logic [N_OUT-1:0] irq_out
);
  function automatic int slot_of(int o);
    int s = 0;
    for (int i = 0; i < o; i++) if (!RSV_MASK[i]) s++;
    return s;
  endfunction

  localparam int EW     = 8 * ELEM_BYTES;
  localparam int N_SLOT = slot_of(N_OUT);
  localparam int NBYTES = N_SLOT * ELEM_BYTES;
  localparam int IW     = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int SW     = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam logic [N_OUT-1:0] BYP = RSV_MASK | SKIP_MASK;
  localparam logic [EW-1:0] SAFE_EL = EW'(SAFE_SEL);

  logic [7:0]    regb [NBYTES];
  logic [AW-1:0] base;
  logic [31:0]   rd_word;

  assign base = {addr[AW-1:2], 2'b00};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NBYTES; k++) regb[k] <= SAFE_EL[8*(k%ELEM_BYTES) +: 8];
    end else if (wr_en) begin
      for (int l = 0; l < 4; l++)
        if (wstrb[l] && (int'(base) + l < NBYTES))
          regb[IW'(int'(base) + l)] <= wdata[8*l +: 8];
    end
  end

  always_comb begin
    rd_word = '0;
    for (int l = 0; l < 4; l++)
      if (int'(base) + l < NBYTES) rd_word[8*l +: 8] = regb[IW'(int'(base) + l)];
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_word;
    else            rdata <= '0;
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    if (BYP[o]) begin : g_byp
      assign irq_out[o] = hw_irq[o];
    end else begin : g_mux
      localparam int S = slot_of(o);
      logic [EW-1:0] sel;
      logic [32:0]   selx;
      for (genvar b = 0; b < ELEM_BYTES; b++) begin : g_b
        assign sel[8*b +: 8] = regb[S*ELEM_BYTES + b];
      end
      assign selx = 33'(sel);
      assign irq_out[o] = (selx < 33'(N_SRC)) ? src_irq[selx[SW-1:0]] : 1'b0;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{addr[1:0], hw_irq & ~BYP};
endmodule

module irq_route_xbar_chk #(
  parameter int N_OUT = 160,
  parameter int N_SRC = 400,
  parameter int ELEM_BYTES = 2,
  parameter int AW = 12,
  parameter logic [N_OUT-1:0] RSV_MASK = '0,
  parameter logic [N_OUT-1:0] SKIP_MASK = '0
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_en,
  input logic [AW-1:0]    addr,
  input logic [31:0]      rdata,
  input logic [N_SRC-1:0] src_irq,
  input logic [N_OUT-1:0] hw_irq,
  input logic [N_OUT-1:0] irq_out
);
  function automatic int cnt_slots();
    int s = 0;
    for (int i = 0; i < N_OUT; i++) if (!RSV_MASK[i]) s++;
    return s;
  endfunction
  localparam int NBYTES = cnt_slots() * ELEM_BYTES;
  localparam int LIM = ((NBYTES + 3) / 4) * 4;
  localparam logic [N_OUT-1:0] BYP = RSV_MASK | SKIP_MASK;

  a_r3_r4_bypass: assert property (@(posedge clk) disable iff (rst)
    ((irq_out ^ hw_irq) & BYP) == '0);

  a_r2_quiet_sources: assert property (@(posedge clk) disable iff (rst)
    (src_irq == '0) |-> ((irq_out & ~BYP) == '0));

  a_r1_level_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && $stable(src_irq) && $stable(hw_irq)) |-> $stable(irq_out));

  a_r9_idle_rdata: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0));

  a_r7_oob_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (int'(addr) >= LIM)) |=> (rdata == '0));
endmodule

bind irq_route_xbar irq_route_xbar_chk #(
  .N_OUT(N_OUT), .N_SRC(N_SRC), .ELEM_BYTES(ELEM_BYTES), .AW(AW),
  .RSV_MASK(RSV_MASK), .SKIP_MASK(SKIP_MASK)
) i_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .src_irq(src_irq), .hw_irq(hw_irq), .irq_out(irq_out)
);

// File: tb/test_irq_route_xbar.sv
module test_irq_route_xbar;
  localparam int N_OUT = 16;
  localparam int N_SRC = 40;
  localparam int EB = 2;
  localparam int AW = 8;
  localparam int SAFE = 3;
  localparam logic [N_OUT-1:0] RSV  = 16'h0023;
  localparam logic [N_OUT-1:0] SKIP = 16'h0080;
  localparam int NB = 26;

  logic clk = 0;
  always #2 clk = ~clk;

  logic rst, wr_en, rd_en;
  logic [AW-1:0] addr;
  logic [31:0] wdata, rdata;
  logic [3:0] wstrb;
  logic [N_SRC-1:0] src_irq;
  logic [N_OUT-1:0] hw_irq, irq_out;

  irq_route_xbar #(.N_OUT(N_OUT), .N_SRC(N_SRC), .ELEM_BYTES(EB), .AW(AW),
    .SAFE_SEL(SAFE), .RSV_MASK(RSV), .SKIP_MASK(SKIP)) i_irq_route_xbar (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .wstrb(wstrb), .rdata(rdata), .src_irq(src_irq),
    .hw_irq(hw_irq), .irq_out(irq_out));

  logic [7:0] m [NB];
  logic [31:0] exp_rdata;
  int vecs = 0, bad = 0;
  string req = "R6";

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NB; k++) m[k] = (k % EB == 0) ? 8'(SAFE) : 8'h00;
      exp_rdata = 0;
    end else begin
      exp_rdata = 0;
      if (rd_en)
        for (int l = 0; l < 4; l++)
          if ((int'(addr) & ~3) + l < NB) exp_rdata[8*l +: 8] = m[(int'(addr) & ~3) + l];
      if (wr_en)
        for (int l = 0; l < 4; l++)
          if (wstrb[l] && (int'(addr) & ~3) + l < NB) m[(int'(addr) & ~3) + l] = wdata[8*l +: 8];
    end
  end

  function automatic int slot(int o);
    int s = 0;
    for (int i = 0; i < o; i++) if (!RSV[i]) s++;
    return s;
  endfunction

  function automatic logic exp_out(int o);
    int s, sel;
    if (RSV[o] || SKIP[o]) return hw_irq[o];
    s = slot(o);
    sel = int'(m[EB*s]) | (int'(m[EB*s+1]) << 8);
    return (sel < N_SRC) ? src_irq[sel] : 1'b0;
  endfunction

  task automatic check();
    vecs++;
    for (int o = 0; o < N_OUT; o++) begin
      logic e;
      e = exp_out(o);
      if (irq_out[o] !== e) begin
        bad++;
        $display("FAIL %s irq_out[%0d] actual %b expected %b",
          RSV[o] ? "R3" : (SKIP[o] ? "R4" : req), o, irq_out[o], e);
      end
    end
    if (rdata !== exp_rdata) begin
      bad++;
      $display("FAIL %s/R7 rdata actual %h expected %h", req, rdata, exp_rdata);
    end
  endtask

  task automatic step(bit w, bit r, int a, logic [31:0] d, logic [3:0] s);
    wr_en = w; rd_en = r; addr = AW'(a); wdata = d; wstrb = s;
    src_irq = {$urandom, $urandom};
    hw_irq = 16'($urandom);
    @(posedge clk);
    @(negedge clk);
    check();
  endtask

  task automatic wr_slot(int s, int v);
    step(1, 0, EB*s, (s % 2) ? (32'(v) << 16) : 32'(v), (s % 2) ? 4'b1100 : 4'b0011);
  endtask

  task automatic read_all();
    for (int a = 0; a < 32; a += 4) step(0, 1, a, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    rst = 1;
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0);
    rst = 0;
    req = "R6"; read_all();
    step(0, 0, 0, 0, 0);
    req = "R5"; for (int s = 0; s < 13; s++) wr_slot(s, (s * 7 + 1) % N_SRC);
    read_all();
    req = "R1"; for (int i = 0; i < 40; i++) step(0, 0, 0, 0, 0);
    req = "R2"; wr_slot(0, 16'hFFFF); wr_slot(1, N_SRC); wr_slot(2, N_SRC - 1);
    wr_slot(5, 16'h0100);
    for (int i = 0; i < 30; i++) step(0, 0, 0, 0, 0);
    req = "R8"; step(1, 0, 4, 32'hA5A5_0203, 4'b0001); step(0, 1, 4, 0, 0);
    step(1, 1, 8, 32'h0009_0011, 4'b1111); step(0, 1, 8, 0, 0);
    step(1, 0, 24, 32'hFFFF_0004, 4'b1111); step(1, 0, 64, 32'h0, 4'b1111);
    read_all();
    req = "R4"; wr_slot(4, 0); wr_slot(4, 12);
    for (int i = 0; i < 10; i++) step(0, 1, 8, 0, 0);
    req = "R9"; for (int i = 0; i < 10; i++) step(0, 0, $urandom % 32, 0, 0);
    req = "R7"; for (int i = 0; i < 10; i++) step(0, 1, 28 + ($urandom % 100), 0, 0);
    req = "R1";
    for (int i = 0; i < 1500; i++) begin
      int v;
      v = ($urandom % 4 == 0) ? int'($urandom % 65536) : int'($urandom % N_SRC);
      step($urandom % 2, $urandom % 2, $urandom % 36, {16'(v), 16'(v)}, 4'($urandom));
    end
    req = "R6"; rst = 1; step(0, 0, 0, 0, 0); rst = 0; read_all();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule